// File: doc/BRIEF.md
# Three-Multiplier Complex Multiplier

This block multiplies a complex data sample x = xr + j·xi by a complex coefficient w = wr + j·wi and returns the product in the data format. It is meant to sit inside a streaming datapath and take one operand pair on every clock. It builds the product from three real multiplies instead of the usual four.

The pre-adders form (xr − xi), (xr + xi) and (wr − wi) in a first register stage. They are one bit wider than their operands, so they never overflow. A second stage registers the three products wi·(xr − xi), wr·(xr + xi) and xr·(wr − wi). A third stage does three things:

- It combines the products into the real part wi·(xr − xi) + xr·(wr − wi), which equals xr·wr − xi·wi.
- It combines the products into the imaginary part wr·(xr + xi) − xr·(wr − wi), which equals xr·wi + xi·wr.
- It rounds both parts back to the data format and saturates them.

All operands are signed two's complement. Data parts are integers. Coefficient parts are in 1.17 format, so the represented value is the integer divided by 2^17. A valid strobe travels alongside the data and marks each result exactly three clocks after its operands were presented. Generating coefficients and any butterfly logic around the multiplier belong to other blocks.

Top module: `trimul_cplx`

## Requirements
- R1: For a valid input, out_re equals the saturated, rounded value of (xr·wr − xi·wi) / 2^17. All values are signed 18-bit two's complement.
- R2: For a valid input, out_im equals the saturated, rounded value of (xr·wi + xi·wr) / 2^17.
- R3: out_vld is high exactly three rising clock edges after the edge that sampled in_vld high. Operands may be valid on every cycle without stalls or lost results.
- R4: Rounding is to nearest, with ties rounded away from zero. An exact quotient of +0.5 gives 1, −0.5 gives −1, and +1.5 gives 2.
- R5: A result above +131071 is replaced by +131071. A result below −131072 is replaced by −131072. No result wraps.
- R6: The full input range gives exact results, including operands of −131072 and differences as large as ±262143 inside the pre-adders.
- R7: While out_vld is low, out_re and out_im keep the last valid result.
- R8: While rst_n is low, out_vld, out_re and out_im are 0.
- R9: A valid input whose sample or coefficient is zero gives out_re = out_im = 0 three cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands on the inputs are valid this cycle |
| in_x_re | input | 18 | Sample real part, signed integer |
| in_x_im | input | 18 | Sample imaginary part, signed integer |
| in_w_re | input | 18 | Coefficient real part, signed 1.17 |
| in_w_im | input | 18 | Coefficient imaginary part, signed 1.17 |
| out_vld | output | 1 | Result on the outputs is valid this cycle |
| out_re | output | 18 | Product real part, signed integer |
| out_im | output | 18 | Product imaginary part, signed integer |

## Verification
The hardest behaviour to reach from the ports is an exact rounding tie, and a tie that also sits next to saturation. Random operands almost never make the 17 discarded bits equal to exactly one half. The stimulus reaches ties directly with a coefficient of 0.5 (integer 65536) and small odd samples of both signs. It reaches the saturation corners with operands at −131072 and +131071, which drive the imaginary sum to ±2^35. Full-rate random traffic with gaps in the valid strobe then tests the hold behaviour and the fixed latency against the behavioural model, which predicts the result on every clock.

// File: rtl/trimul_pkg.sv
package trimul_pkg;
   // default widths of the complex multiplier library block
   localparam int TM_DATA_W    = 18;
   localparam int TM_COEF_W    = 18;
   localparam int TM_FRAC_W    = 17;
   localparam int TM_OUT_W     = 18;
   localparam int TM_MUL_LIMIT = 18;
   localparam int TM_LATENCY   = 3;

   typedef enum logic {
      LANE_RE = 1'b0,
      LANE_IM = 1'b1
   } lane_e;
endpackage

// File: rtl/trimul_preadd.sv
module trimul_preadd #(
   parameter int DATA_W = 18,
   parameter int COEF_W = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [DATA_W-1:0] x_re_i,
   input  logic signed [DATA_W-1:0] x_im_i,
   input  logic signed [COEF_W-1:0] w_re_i,
   input  logic signed [COEF_W-1:0] w_im_i,
   output logic                     vld_o,
   output logic signed [DATA_W-1:0] x_re_o,
   output logic signed [COEF_W-1:0] w_re_o,
   output logic signed [COEF_W-1:0] w_im_o,
   output logic signed [DATA_W:0]   x_dif_o,
   output logic signed [DATA_W:0]   x_sum_o,
   output logic signed [COEF_W:0]   w_dif_o
);
   localparam int XE_W = DATA_W + 1;
   localparam int WE_W = COEF_W + 1;

   logic signed [XE_W-1:0] xr_ext, xi_ext;
   logic signed [WE_W-1:0] wr_ext, wi_ext;
   logic signed [XE_W-1:0] x_dif, x_sum;
   logic signed [WE_W-1:0] w_dif;

   // sign extension by one bit so the pre-adders cannot overflow
   assign xr_ext = {x_re_i[DATA_W-1], x_re_i};
   assign xi_ext = {x_im_i[DATA_W-1], x_im_i};
   assign wr_ext = {w_re_i[COEF_W-1], w_re_i};
   assign wi_ext = {w_im_i[COEF_W-1], w_im_i};

   assign x_dif = xr_ext - xi_ext;
   assign x_sum = xr_ext + xi_ext;
   assign w_dif = wr_ext - wi_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         x_re_o  <= '0;
         w_re_o  <= '0;
         w_im_o  <= '0;
         x_dif_o <= '0;
         x_sum_o <= '0;
         w_dif_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            x_re_o  <= x_re_i;
            w_re_o  <= w_re_i;
            w_im_o  <= w_im_i;
            x_dif_o <= x_dif;
            x_sum_o <= x_sum;
            w_dif_o <= w_dif;
         end
      end
   end
endmodule

// File: rtl/trimul_mulstage.sv
module trimul_mulstage #(
   parameter int DATA_W = 18,
   parameter int COEF_W = 18
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            vld_i,
   input  logic signed [DATA_W-1:0]        x_re_i,
   input  logic signed [COEF_W-1:0]        w_re_i,
   input  logic signed [COEF_W-1:0]        w_im_i,
   input  logic signed [DATA_W:0]          x_dif_i,
   input  logic signed [DATA_W:0]          x_sum_i,
   input  logic signed [COEF_W:0]          w_dif_i,
   output logic                            vld_o,
   output logic signed [DATA_W+COEF_W:0]   p_wi_xdif_o,
   output logic signed [DATA_W+COEF_W:0]   p_wr_xsum_o,
   output logic signed [DATA_W+COEF_W:0]   p_xr_wdif_o
);
   localparam int PROD_W = DATA_W + COEF_W + 1;

   logic signed [PROD_W-1:0] m_a, m_b, m_c;

   // the three real multipliers
   assign m_a = w_im_i * x_dif_i;
   assign m_b = w_re_i * x_sum_i;
   assign m_c = x_re_i * w_dif_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o       <= 1'b0;
         p_wi_xdif_o <= '0;
         p_wr_xsum_o <= '0;
         p_xr_wdif_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            p_wi_xdif_o <= m_a;
            p_wr_xsum_o <= m_b;
            p_xr_wdif_o <= m_c;
         end
      end
   end
endmodule

// File: rtl/trimul_rndsat.sv
module trimul_rndsat #(
   parameter int IN_W   = 38,
   parameter int FRAC_W = 17,
   parameter int OUT_W  = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic signed [IN_W-1:0]  sum_i,
   output logic signed [OUT_W-1:0] q_o
);
   localparam int EXT_W = IN_W + 1;
   localparam int SH_W  = EXT_W - FRAC_W;
   localparam logic signed [SH_W-1:0] MAXV =
      $signed({{(SH_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
   localparam logic signed [SH_W-1:0] MINV = ~MAXV;

   logic signed [EXT_W-1:0] sum_x, half, neg_adj, rnd;
   logic signed [SH_W-1:0]  scaled;
   logic [FRAC_W-1:0]       frac_unused;
   logic signed [OUT_W-1:0] sat;

   assign sum_x   = {sum_i[IN_W-1], sum_i};
   assign half    = $signed({{(EXT_W-1){1'b0}}, 1'b1} << (FRAC_W - 1));
   // one less on negative values turns round-half-up into half-away
   assign neg_adj = $signed({{(EXT_W-1){1'b0}}, sum_i[IN_W-1]});
   assign rnd     = sum_x + half - neg_adj;

   assign scaled      = rnd[EXT_W-1:FRAC_W];
   assign frac_unused = rnd[FRAC_W-1:0];

   always_comb begin
      if (scaled > MAXV)
         sat = MAXV[OUT_W-1:0];
      else if (scaled < MINV)
         sat = MINV[OUT_W-1:0];
      else
         sat = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (en_i)
         q_o <= sat;
   end
endmodule

// File: rtl/trimul_cplx.sv
module trimul_cplx
   import trimul_pkg::*;
#(
   parameter int DATA_W    = TM_DATA_W,
   parameter int COEF_W    = TM_COEF_W,
   parameter int FRAC_W    = TM_FRAC_W,
   parameter int OUT_W     = TM_OUT_W,
   parameter int MUL_LIMIT = TM_MUL_LIMIT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic signed [DATA_W-1:0] in_x_re,
   input  logic signed [DATA_W-1:0] in_x_im,
   input  logic signed [COEF_W-1:0] in_w_re,
   input  logic signed [COEF_W-1:0] in_w_im,
   output logic                     out_vld,
   output logic signed [OUT_W-1:0]  out_re,
   output logic signed [OUT_W-1:0]  out_im
);
   localparam int PROD_W = DATA_W + COEF_W + 1;
   localparam int SUM_W  = PROD_W + 1;
   localparam int LANES  = 2;

   // elaboration-time parameter checks
   if (DATA_W > MUL_LIMIT || COEF_W > MUL_LIMIT) begin : g_bad_width
      $error("trimul_cplx: operand width exceeds multiplier limit");
   end
   if (FRAC_W < 1 || FRAC_W >= DATA_W + COEF_W) begin : g_bad_frac
      $error("trimul_cplx: FRAC_W out of range");
   end
   if (OUT_W < 2 || OUT_W > SUM_W - FRAC_W) begin : g_bad_out
      $error("trimul_cplx: OUT_W out of range");
   end

   logic                     v1, v2;
   logic signed [DATA_W-1:0] s1_xr;
   logic signed [COEF_W-1:0] s1_wr, s1_wi;
   logic signed [DATA_W:0]   s1_xdif, s1_xsum;
   logic signed [COEF_W:0]   s1_wdif;
   logic signed [PROD_W-1:0] p_a, p_b, p_c;
   logic signed [OUT_W-1:0]  lane_q [LANES];

   trimul_preadd #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .vld_i(in_vld),
      .x_re_i(in_x_re), .x_im_i(in_x_im),
      .w_re_i(in_w_re), .w_im_i(in_w_im),
      .vld_o(v1), .x_re_o(s1_xr), .w_re_o(s1_wr), .w_im_o(s1_wi),
      .x_dif_o(s1_xdif), .x_sum_o(s1_xsum), .w_dif_o(s1_wdif)
   );

   trimul_mulstage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .vld_i(v1),
      .x_re_i(s1_xr), .w_re_i(s1_wr), .w_im_i(s1_wi),
      .x_dif_i(s1_xdif), .x_sum_i(s1_xsum), .w_dif_i(s1_wdif),
      .vld_o(v2), .p_wi_xdif_o(p_a), .p_wr_xsum_o(p_b), .p_xr_wdif_o(p_c)
   );

   // post-adders and round/saturate, one lane per output part
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [SUM_W-1:0] lane_sum;
      if (g == int'(LANE_RE)) begin : g_re
         assign lane_sum = $signed({p_a[PROD_W-1], p_a}) + $signed({p_c[PROD_W-1], p_c});
      end else begin : g_im
         assign lane_sum = $signed({p_b[PROD_W-1], p_b}) - $signed({p_c[PROD_W-1], p_c});
      end
      trimul_rndsat #(.IN_W(SUM_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rs (
         .clk(clk), .rst_n(rst_n), .en_i(v2),
         .sum_i(lane_sum), .q_o(lane_q[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_vld <= 1'b0;
      else
         out_vld <= v2;
   end

   assign out_re = lane_q[int'(LANE_RE)];
   assign out_im = lane_q[int'(LANE_IM)];

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (out_vld == $past(in_vld, 3)));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !out_vld) |-> ($stable(out_re) && $stable(out_im)));

   // R9
   zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) &&
       $past(in_vld && in_w_re == '0 && in_w_im == '0, 3))
      |-> (out_re == '0 && out_im == '0));

   // R9
   zero_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) &&
       $past(in_vld && in_x_re == '0 && in_x_im == '0, 3))
      |-> (out_re == '0 && out_im == '0));
endmodule

// File: tb/test_trimul_cplx.sv
`timescale 1ns/1ps
module test_trimul_cplx;
   localparam int  FRAC = 17;
   localparam int  OMAX = 131071;
   localparam int  OMIN = -131072;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic signed [17:0] in_x_re = '0, in_x_im = '0, in_w_re = '0, in_w_im = '0;
   logic out_vld;
   logic signed [17:0] out_re, out_im;

   always #2 clk = ~clk;

   trimul_cplx i_trimul_cplx (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .in_x_re(in_x_re), .in_x_im(in_x_im), .in_w_re(in_w_re), .in_w_im(in_w_im),
      .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
   );

   typedef struct {
      bit    v;
      int    re;
      int    im;
      string tre;
      string tim;
   } exp_t;

   exp_t q[$];
   int   hold_re = 0, hold_im = 0;
   int   n_tests = 0, n_fail = 0;
   bit   finished = 1'b0;

   function automatic int ref_q(longint x);
      longint r;
      if (x >= 0) r = (x + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
      else        r = -((-x + (64'sd1 <<< (FRAC - 1))) >>> FRAC);
      if (r > OMAX) r = OMAX;
      if (r < OMIN) r = OMIN;
      return int'(r);
   endfunction

   function automatic int rnd18();
      logic [17:0] r;
      r = 18'($urandom);
      if (($urandom % 8) == 0) r = (($urandom % 2) == 0) ? 18'h20000 : 18'h1FFFF;
      return int'($signed(r));
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one clock: compare outputs due now, then present new operands
   task automatic step(bit v, int a, int b, int c, int d, string tre, string tim);
      exp_t e, n;
      longint lre, lim;
      @(negedge clk);
      if (q.size() == 3) begin
         e = q.pop_front();
         chk("R3", "out_vld", int'(out_vld), int'(e.v));
         if (e.v) begin
            hold_re = e.re;
            hold_im = e.im;
            chk(e.tre, "out_re", int'(out_re), e.re);
            chk(e.tim, "out_im", int'(out_im), e.im);
         end else begin
            chk("R7", "held out_re", int'(out_re), hold_re);
            chk("R7", "held out_im", int'(out_im), hold_im);
         end
      end
      in_vld  = v;
      in_x_re = 18'(a);
      in_x_im = 18'(b);
      in_w_re = 18'(c);
      in_w_im = 18'(d);
      lre = longint'(a) * c - longint'(b) * d;
      lim = longint'(a) * d + longint'(b) * c;
      n.v = v;
      n.re = ref_q(lre);
      n.im = ref_q(lim);
      n.tre = tre;
      n.tim = tim;
      q.push_back(n);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R3 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R8 reset state
      repeat (3) @(negedge clk);
      chk("R8", "out_vld in reset", int'(out_vld), 0);
      chk("R8", "out_re in reset", int'(out_re), 0);
      chk("R8", "out_im in reset", int'(out_im), 0);
      rst_n = 1'b1;

      // R1 R2 plain products, back to back
      step(1, 1000, 2000, 65536, 32768, "R1", "R2");
      step(1, -5000, 700, 131071, -65536, "R1", "R2");
      step(1, 12345, -23456, -40000, 99999, "R1", "R2");
      // R4 exact ties, both signs
      step(1, 1, 0, 65536, 0, "R4", "R4");
      step(1, -1, 0, 65536, 0, "R4", "R4");
      step(1, 3, 0, 65536, 0, "R4", "R4");
      step(1, 0, -3, 0, 65536, "R4", "R4");
      // R5 saturation corners
      step(1, -131072, 0, -131072, 0, "R5", "R5");
      step(1, -131072, -131072, -131072, -131072, "R5", "R5");
      step(1, -131072, -131072, 131071, 131071, "R5", "R5");
      // R6 extreme pre-adder differences
      step(1, -131072, 131071, 1, 0, "R6", "R6");
      step(1, 1, 0, -131072, 131071, "R6", "R6");
      step(1, 131071, -131072, 131071, -131072, "R6", "R6");
      // R9 zero operands
      step(1, 77777, -1234, 0, 0, "R9", "R9");
      step(1, 0, 0, 99999, -99999, "R9", "R9");
      // R7 gaps with garbage on the data inputs
      step(0, 131071, 131071, 131071, 131071, "R7", "R7");
      step(0, -555, 444, -333, 222, "R7", "R7");
      step(0, 9, 9, 9, 9, "R7", "R7");
      step(1, 4242, -4242, 100000, 20000, "R1", "R2");
      step(0, 0, 0, 0, 0, "R7", "R7");

      // R1 R2 R3 random traffic with random valid gaps
      for (int i = 0; i < 600; i++) begin
         step(($urandom % 4) != 0, rnd18(), rnd18(), rnd18(), rnd18(), "R1", "R2");
      end
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R7", "R7");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule